// File: doc/BRIEF.md
# Flash Sector Map and Write Protection

This block sits beside the array controller of a 2M-word by 16-bit flash memory. It turns a 21-bit word address into a bank number and a sector number. It also decides whether a program or erase aimed at that address may go ahead. The array has two banks. The lower bank holds 512K words and starts with eight 4K-word sectors, followed by fifteen 32K-word sectors. The upper bank holds 1536K words in forty-eight 32K-word sectors. Sectors are numbered 0 to 70 from the bottom of the address space upward.

The permit decision combines four conditions:
- a per-sector lock bit, which software sets and clears with strobes that carry a sector address;
- a write-protect pin, which guards the lowest and the highest sector;
- a flag that reports the programming voltage as low;
- a flag that reports the supply as low.

All of these arrive as clean digital signals. The command parser that raises the strobes and consumes the permit lives elsewhere.

Top module: `flash_sector_guard`

## Requirements
- R1: `bank_o` is 0 for word addresses below 0x80000 and 1 for addresses from 0x80000 to 0x1FFFFF.
- R2: For addresses below 0x8000, `sector_o` equals address bits [14:12], giving sectors 0 to 7 of 4K words each.
- R3: For addresses from 0x8000 upward, `sector_o` equals 7 plus address bits [20:15], giving sectors 8 to 70 of 32K words each. Sectors 8 to 22 lie in bank 0 and sectors 23 to 70 lie in bank 1.
- R4: After a synchronous active-low reset, every lock bit is clear. With `wp_n_i`=1, `vpp_hi_i`=1 and `vdd_low_i`=0, `write_ok_o` is then 1 for every address.
- R5: A cycle with `lock_stb_i`=1 sets the lock bit of the sector that holds `cmd_addr_i`. From the next cycle on, `write_ok_o` is 0 for every address in that sector, and the other sectors are unaffected.
- R6: A cycle with `unlock_stb_i`=1 and `lock_stb_i`=0 clears the lock bit of the sector that holds `cmd_addr_i`. From the next cycle on, that sector is writable again.
- R7: When both strobes are high in the same cycle, the addressed sector ends up locked.
- R8: While `wp_n_i`=0, `write_ok_o` is 0 for sectors 0 and 70 whatever their lock bits hold. All other sectors are unaffected.
- R9: While `vpp_hi_i`=0, `write_ok_o` is 0 for every address.
- R10: While `vdd_low_i`=1, `write_ok_o` is 0 for every address.
- R11: `bank_o`, `sector_o` and `write_ok_o` are combinational from the address, the flags and the lock bits. They follow a change of those inputs in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the lock bits |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 21 | Word address of the program or erase being checked |
| wp_n_i | input | 1 | Write-protect pin, active low |
| vpp_hi_i | input | 1 | Programming voltage adequate (0 = low) |
| vdd_low_i | input | 1 | Supply-low flag (1 = inhibit writes) |
| lock_stb_i | input | 1 | Lock the sector addressed by cmd_addr_i |
| unlock_stb_i | input | 1 | Unlock the sector addressed by cmd_addr_i |
| cmd_addr_i | input | 21 | Any word address inside the sector being locked or unlocked |
| bank_o | output | 1 | Bank of addr_i |
| sector_o | output | 7 | Sector number of addr_i, 0 to 70 |
| write_ok_o | output | 1 | Program or erase at addr_i is permitted |

## Verification
The decode outputs and the permit flag have no register on their path. The bench therefore changes an address or a flag half a period away from the rising edge and samples 1 ns later, with no edge in between. A lock or unlock strobe is driven on a falling edge and takes effect at the following rising edge. It is checked 1 ns after that edge, with the strobe already low again, so that each check falls exactly one cycle after its stimulus. The cycle before the strobe lands is also checked, to show that the bit has not yet moved.

// File: rtl/flash_map_pkg.sv
// Shared geometry of the two-bank flash address map.
// Assumes: small sectors fill a whole number of big-sector slots at address 0.
package flash_map_pkg;
    localparam int ADDR_W      = 21;  // word address width
    localparam int SMALL_SZ_W  = 12;  // log2 words per small sector
    localparam int BIG_SZ_W    = 15;  // log2 words per big sector
    localparam int N_SMALL     = 8;   // small sectors at the bottom
    localparam int LOW_BANK_BIG = 15; // big sectors in the low bank

    localparam int BIG_IDX_W   = ADDR_W - BIG_SZ_W;
    localparam int SMALL_IDX_W = ADDR_W - SMALL_SZ_W;
    localparam int SMALL_SPAN  = (N_SMALL << SMALL_SZ_W) >> BIG_SZ_W;
    localparam int N_SECT      = N_SMALL + (1 << BIG_IDX_W) - SMALL_SPAN;
    localparam int SECT_W      = $clog2(N_SECT);
    localparam int BANK_SPLIT  = SMALL_SPAN + LOW_BANK_BIG;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [SECT_W-1:0] sect_t;
endpackage

// File: rtl/flash_sector_decode.sv
// Maps a word address to its bank and sector number.
// Assumes: the address is in range; purely combinational.
module flash_sector_decode
    import flash_map_pkg::*;
(
    input  waddr_t addr,
    output logic   bank,
    output sect_t  sector
);
    localparam logic [BIG_IDX_W-1:0] SPAN_IDX  = BIG_IDX_W'(SMALL_SPAN);
    localparam logic [BIG_IDX_W-1:0] SPLIT_IDX = BIG_IDX_W'(BANK_SPLIT);
    localparam sect_t BIG_BASE = SECT_W'(N_SMALL - SMALL_SPAN);

    logic [BIG_IDX_W-1:0]   big_idx;
    logic [SMALL_IDX_W-1:0] small_idx;

    assign big_idx   = addr[ADDR_W-1:BIG_SZ_W];
    assign small_idx = addr[ADDR_W-1:SMALL_SZ_W];

    // Pick small-sector or big-sector numbering and the bank.
    always_comb begin
        bank = (big_idx >= SPLIT_IDX);
        if (big_idx < SPAN_IDX)
            sector = SECT_W'(small_idx);
        else
            sector = BIG_BASE + SECT_W'(big_idx);
    end
endmodule

// File: rtl/flash_lock_bits.sv
// One lock flop per sector, set or cleared by sector-addressed strobes.
// Assumes: lock wins when both strobes arrive together.
module flash_lock_bits
    import flash_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  sect_t             cmd_sect,
    output logic [N_SECT-1:0] locked
);
    for (genvar g = 0; g < N_SECT; g++) begin : g_bit
        logic hit;
        assign hit = (cmd_sect == SECT_W'(g));
        // Hold, set or clear this sector's lock bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                locked[g] <= 1'b0;
            else if (set_stb && hit)
                locked[g] <= 1'b1;
            else if (clr_stb && hit)
                locked[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_write_permit.sv
// Combines lock bit, write-protect pin and the two voltage flags.
// Assumes: flags are synchronous clean levels.
module flash_write_permit
    import flash_map_pkg::*;
(
    input  sect_t sector,
    input  logic  sect_locked,
    input  logic  wp_n,
    input  logic  vpp_hi,
    input  logic  vdd_low,
    output logic  permit
);
    localparam sect_t TOP_SECT = SECT_W'(N_SECT - 1);

    logic outer;
    logic pin_block;

    // Outermost sectors are the ones the protect pin guards.
    always_comb begin
        outer     = (sector == '0) || (sector == TOP_SECT);
        pin_block = outer && !wp_n;
    end

    // Any blocking source vetoes the operation.
    always_comb begin
        permit = vpp_hi && !vdd_low && !pin_block && !sect_locked;
    end
endmodule

// File: rtl/flash_sector_guard.sv
// Top: address decode, per-sector locks and write-permit decision.
// Assumes: strobes are single-cycle requests from a command parser.
module flash_sector_guard
    import flash_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [20:0] addr_i,
    input  logic        wp_n_i,
    input  logic        vpp_hi_i,
    input  logic        vdd_low_i,
    input  logic        lock_stb_i,
    input  logic        unlock_stb_i,
    input  logic [20:0] cmd_addr_i,
    output logic        bank_o,
    output logic [6:0]  sector_o,
    output logic        write_ok_o
);
    sect_t             q_sect;
    sect_t             c_sect;
    logic              c_bank;
    logic [N_SECT-1:0] locked;

    flash_sector_decode u_dec_q (
        .addr   (addr_i),
        .bank   (bank_o),
        .sector (q_sect)
    );

    flash_sector_decode u_dec_c (
        .addr   (cmd_addr_i),
        .bank   (c_bank),
        .sector (c_sect)
    );

    flash_lock_bits u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (lock_stb_i),
        .clr_stb  (unlock_stb_i),
        .cmd_sect (c_sect),
        .locked   (locked)
    );

    flash_write_permit u_perm (
        .sector      (q_sect),
        .sect_locked (locked[q_sect]),
        .wp_n        (wp_n_i),
        .vpp_hi      (vpp_hi_i),
        .vdd_low     (vdd_low_i),
        .permit      (write_ok_o)
    );

    assign sector_o = q_sect;

    logic unused_c_bank;
    assign unused_c_bank = c_bank;
endmodule

// File: rtl/flash_sector_guard_chk.sv
// Checker for flash_sector_guard; observes ports only.
module flash_sector_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [20:0] addr_i,
    input logic        wp_n_i,
    input logic        vpp_hi_i,
    input logic        vdd_low_i,
    input logic        lock_stb_i,
    input logic        unlock_stb_i,
    input logic [20:0] cmd_addr_i,
    input logic        bank_o,
    input logic [6:0]  sector_o,
    input logic        write_ok_o
);
    // R1
    bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o == (sector_o >= 7'd23));

    // R2
    small_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i < 21'h8000) |-> (sector_o < 7'd8));

    // R3
    sector_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_o <= 7'd70);

    // R5
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_stb_i) && addr_i == $past(cmd_addr_i)) |-> !write_ok_o);

    // R6
    unlock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(unlock_stb_i) && !$past(lock_stb_i)
         && addr_i == $past(cmd_addr_i) && wp_n_i && vpp_hi_i && !vdd_low_i) |-> write_ok_o);

    // R8
    wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && (sector_o == 7'd0 || sector_o == 7'd70)) |-> !write_ok_o);

    // R9
    vpp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_hi_i |-> !write_ok_o);

    // R10
    vdd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low_i |-> !write_ok_o);
endmodule

bind flash_sector_guard flash_sector_guard_chk u_chk (.*);

// File: tb/sim_flash_sector_guard.sv
module sim_flash_sector_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] addr_i = '0;
    logic        wp_n_i = 1'b1;
    logic        vpp_hi_i = 1'b1;
    logic        vdd_low_i = 1'b0;
    logic        lock_stb_i = 1'b0;
    logic        unlock_stb_i = 1'b0;
    logic [20:0] cmd_addr_i = '0;
    logic        bank_o;
    logic [6:0]  sector_o;
    logic        write_ok_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_sector_guard u0 (.*);

    function automatic int exp_sect(int a);
        if (a < 32768) return a / 4096;
        return 7 + a / 32768;
    endfunction

    task automatic check(int act, int exp, string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Combinational probe: set address away from the edge, sample 1 ns later.
    task automatic probe(int a, int exp_ok, string req);
        @(negedge clk);
        addr_i = 21'(a);
        #1;
        check(int'(write_ok_o), exp_ok, req);
    endtask

    // Strobe for one cycle; effect checked 1 ns after the next rising edge.
    task automatic strobe(bit lk, bit ul, int a);
        @(negedge clk);
        cmd_addr_i = 21'(a);
        lock_stb_i = lk;
        unlock_stb_i = ul;
        @(posedge clk);
        #1;
        lock_stb_i = 1'b0;
        unlock_stb_i = 1'b0;
    endtask

    task automatic t_reset();
        probe(0, 1, "R4");
        probe(21'h1FFFFF, 1, "R4");
        probe(21'h0C0000, 1, "R4");
    endtask

    task automatic t_decode();
        int pts[10] = '{0, 'hFFF, 'h1000, 'h7FFF, 'h8000, 'h7FFFF,
                        'h80000, 'h100000, 'h1F8000, 'h1FFFFF};
        foreach (pts[i]) begin
            @(negedge clk);
            addr_i = 21'(pts[i]);
            #1;
            check(int'(bank_o), (pts[i] >= 'h80000) ? 1 : 0, "R1");
            check(int'(sector_o), exp_sect(pts[i]), pts[i] < 'h8000 ? "R2" : "R3");
        end
        @(negedge clk);
        addr_i = 21'h7FFFF;
        #1;
        check(int'(sector_o), 22, "R3");
        addr_i = 21'h80000;
        #1;
        check(int'(sector_o), 23, "R11");
    endtask

    task automatic t_lock();
        @(negedge clk);
        addr_i = 21'h3000;
        cmd_addr_i = 21'h3ABC;
        lock_stb_i = 1'b1;
        #1;
        check(int'(write_ok_o), 1, "R5");
        @(posedge clk);
        #1;
        lock_stb_i = 1'b0;
        check(int'(write_ok_o), 0, "R5");
        probe('h3FFF, 0, "R5");
        probe('h2FFF, 1, "R5");
        probe('h4000, 1, "R5");
        strobe(1, 0, 33 * 32768 + 5);
        probe(33 * 32768, 0, "R5");
        probe(34 * 32768, 1, "R5");
    endtask

    task automatic t_unlock();
        strobe(0, 1, 'h3000);
        probe('h3000, 1, "R6");
        probe(33 * 32768 + 100, 0, "R6");
        strobe(0, 1, 33 * 32768);
        probe(33 * 32768 + 100, 1, "R6");
    endtask

    task automatic t_both();
        strobe(1, 1, 'h18000);
        probe('h18000, 0, "R7");
        strobe(0, 1, 'h18000);
        probe('h18000, 1, "R7");
    endtask

    task automatic t_wp();
        @(negedge clk);
        wp_n_i = 1'b0;
        addr_i = 21'h0;
        #1;
        check(int'(write_ok_o), 0, "R8");
        probe('h1FFFFF, 0, "R8");
        probe('h1F8000, 0, "R8");
        probe('h1000, 1, "R8");
        probe('h1F7FFF, 1, "R8");
        @(negedge clk);
        wp_n_i = 1'b1;
        #1;
        check(int'(write_ok_o), 1, "R8");
    endtask

    task automatic t_vpp();
        @(negedge clk);
        addr_i = 21'h90000;
        vpp_hi_i = 1'b0;
        #1;
        check(int'(write_ok_o), 0, "R9");
        probe('h1000, 0, "R9");
        @(negedge clk);
        vpp_hi_i = 1'b1;
        #1;
        check(int'(write_ok_o), 1, "R11");
    endtask

    task automatic t_vdd();
        @(negedge clk);
        addr_i = 21'h40000;
        vdd_low_i = 1'b1;
        #1;
        check(int'(write_ok_o), 0, "R10");
        probe('h1FFFFF, 0, "R10");
        @(negedge clk);
        vdd_low_i = 1'b0;
        #1;
        check(int'(write_ok_o), 1, "R10");
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_lock();
        t_unlock();
        t_both();
        t_wp();
        t_vpp();
        t_vdd();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule